// File: doc/BRIEF.md
# Watchdog and Supply Reset Supervisor

This block produces the reset for a microcontroller from two sources. The first is a watchdog counter that the host must service with a one-cycle kick strobe. The second is a digital low-supply flag that comes from an external comparator. The watchdog period comes from a two-bit selection input. That input is expected to come from a persistent register, so the chosen period survives power cycles. The selection gives three fixed periods, and its fourth code turns the watchdog off.

A low-supply flag asserts reset in the same cycle, with no register in the path. Reset then stays asserted until the flag has been inactive for a fixed number of consecutive cycles. Power-on reset goes through the same settling wait. A watchdog expiry produces a reset pulse of fixed minimum width. After that pulse the counter runs again from zero. Reset is driven in both polarities.

Top module: `wdt_supervisor`

## Requirements
- R1: With `intervalSel` = 00, 01 or 10, and no kick, reset rises after exactly 2^SHORT_LOG2, 2^MED_LOG2 or 2^LONG_LOG2 cycles in the running state. The count starts from the first cycle with reset deasserted.
- R2: With `intervalSel` = 11, the watchdog never asserts reset. The counter is held at zero, so a later switch to 00 gives a full short period.
- R3: A watchdog expiry asserts reset for exactly PULSE_TICKS cycles. Reset is then released and the watchdog count restarts from zero.
- R4: `supplyLow` high forces reset high in the same cycle, combinationally.
- R5: After `supplyLow` falls, reset stays high for SETTLE_TICKS consecutive cycles with `supplyLow` low. Any return of `supplyLow` during this wait restarts the count.
- R6: A kick while running clears the watchdog counter. A kick while reset is asserted has no effect and does not shorten a reset pulse.
- R7: `resetOutN` is always the complement of `resetOut`.
- R8: While `rstN` is low, reset is asserted. After `rstN` is released, the same settling wait as in R5 applies.
- R9: If `supplyLow` goes active during a watchdog pulse, the settling wait of R5 takes over from the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| kick | input | 1 | One-cycle watchdog service strobe |
| intervalSel | input | 2 | Persistent period select: 00 short, 01 medium, 10 long, 11 off |
| supplyLow | input | 1 | Low-supply flag from the comparator, active high |
| resetOut | output | 1 | System reset, active high |
| resetOutN | output | 1 | System reset, active low |

## Verification
The checker enforces four rules on every cycle. A low-supply flag always shows as reset. Reset never falls before the required number of good-supply cycles has passed. Every reset that ends has lasted at least the shorter of the pulse and settle widths. A kick while running, or the disabled code, keeps reset low on the next cycle.

The exact period for each select code, the exact pulse width and the restart of the settle count need the bench scenarios. The same holds for takeover by a supply event during a pulse and for a kick that is ignored during reset. The bench measures each of these as a cycle count at the ports.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PULSE = 2'd2
  } supState_t;

  typedef struct packed {
    logic wdClr;
    logic wdInc;
    logic settleClr;
    logic settleInc;
    logic pulseClr;
    logic pulseInc;
  } supStrobes_t;

  localparam logic [1:0] SEL_SHORT = 2'b00;
  localparam logic [1:0] SEL_MED   = 2'b01;
  localparam logic [1:0] SEL_LONG  = 2'b10;
  localparam logic [1:0] SEL_OFF   = 2'b11;

endpackage

// File: rtl/wdsup_counter.sv
module wdsup_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/wdsup_datapath.sv
module wdsup_datapath
  import wdsup_pkg::*;
#(
  parameter int SHORT_LOG2   = 10,
  parameter int MED_LOG2     = 14,
  parameter int LONG_LOG2    = 17,
  parameter int SETTLE_TICKS = 1000,
  parameter int PULSE_TICKS  = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  supStrobes_t strobes,
  input  logic [1:0]  intervalSel,
  output logic        wdEnabled,
  output logic        wdAtLimit,
  output logic        settleAtEnd,
  output logic        pulseAtEnd
);

  localparam int WD_W     = LONG_LOG2;
  localparam int SETTLE_W = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
  localparam int PULSE_W  = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;

  localparam logic [WD_W:0] LIM_SHORT = (WD_W+1)'(1) << SHORT_LOG2;
  localparam logic [WD_W:0] LIM_MED   = (WD_W+1)'(1) << MED_LOG2;
  localparam logic [WD_W:0] LIM_LONG  = (WD_W+1)'(1) << LONG_LOG2;

  localparam logic [SETTLE_W-1:0] SETTLE_LAST = SETTLE_W'(SETTLE_TICKS - 1);
  localparam logic [PULSE_W-1:0]  PULSE_LAST  = PULSE_W'(PULSE_TICKS - 1);

  logic [WD_W-1:0]     wdCount;
  logic [SETTLE_W-1:0] settleCount;
  logic [PULSE_W-1:0]  pulseCount;
  logic [WD_W:0]       wdLimit;

  wdsup_counter #(.W(WD_W)) uWdCnt (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobes.wdClr),
    .inc  (strobes.wdInc),
    .count(wdCount)
  );

  wdsup_counter #(.W(SETTLE_W)) uSettleCnt (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobes.settleClr),
    .inc  (strobes.settleInc),
    .count(settleCount)
  );

  wdsup_counter #(.W(PULSE_W)) uPulseCnt (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobes.pulseClr),
    .inc  (strobes.pulseInc),
    .count(pulseCount)
  );

  always_comb begin
    case (intervalSel)
      SEL_SHORT: wdLimit = LIM_SHORT;
      SEL_MED:   wdLimit = LIM_MED;
      SEL_LONG:  wdLimit = LIM_LONG;
      default:   wdLimit = LIM_LONG;
    endcase
  end

  // A greater-or-equal compare covers a switch to a shorter period mid-count.
  assign wdEnabled   = (intervalSel != SEL_OFF);
  assign wdAtLimit   = ({1'b0, wdCount} >= (wdLimit - 1'b1));
  assign settleAtEnd = (settleCount == SETTLE_LAST);
  assign pulseAtEnd  = (pulseCount == PULSE_LAST);

endmodule

// File: rtl/wdsup_ctrl.sv
module wdsup_ctrl
  import wdsup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        kick,
  input  logic        supplyLow,
  input  logic        wdEnabled,
  input  logic        wdAtLimit,
  input  logic        settleAtEnd,
  input  logic        pulseAtEnd,
  output supStrobes_t strobes,
  output logic        running
);

  supState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      ST_RUN: begin
        strobes.wdClr = kick | ~wdEnabled;
        strobes.wdInc = ~strobes.wdClr;
        if (supplyLow) begin
          stateNext         = ST_HOLD;
          strobes.settleClr = 1'b1;
        end else if (strobes.wdInc && wdAtLimit) begin
          stateNext        = ST_PULSE;
          strobes.pulseClr = 1'b1;
          strobes.wdClr    = 1'b1;
          strobes.wdInc    = 1'b0;
        end
      end
      ST_PULSE: begin
        strobes.wdClr = 1'b1;
        if (supplyLow) begin
          stateNext         = ST_HOLD;
          strobes.settleClr = 1'b1;
        end else if (pulseAtEnd) begin
          stateNext = ST_RUN;
        end else begin
          strobes.pulseInc = 1'b1;
        end
      end
      default: begin
        strobes.wdClr = 1'b1;
        if (supplyLow) begin
          strobes.settleClr = 1'b1;
        end else if (settleAtEnd) begin
          stateNext = ST_RUN;
        end else begin
          strobes.settleInc = 1'b1;
        end
      end
    endcase
  end

  assign running = (state == ST_RUN);

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdsup_pkg::*;
#(
  parameter int SHORT_LOG2   = 10,
  parameter int MED_LOG2     = 14,
  parameter int LONG_LOG2    = 17,
  parameter int SETTLE_TICKS = 1000,
  parameter int PULSE_TICKS  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       kick,
  input  logic [1:0] intervalSel,
  input  logic       supplyLow,
  output logic       resetOut,
  output logic       resetOutN
);

  supStrobes_t strobes;
  logic wdEnabled, wdAtLimit, settleAtEnd, pulseAtEnd, running;

  wdsup_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .kick       (kick),
    .supplyLow  (supplyLow),
    .wdEnabled  (wdEnabled),
    .wdAtLimit  (wdAtLimit),
    .settleAtEnd(settleAtEnd),
    .pulseAtEnd (pulseAtEnd),
    .strobes    (strobes),
    .running    (running)
  );

  wdsup_datapath #(
    .SHORT_LOG2  (SHORT_LOG2),
    .MED_LOG2    (MED_LOG2),
    .LONG_LOG2   (LONG_LOG2),
    .SETTLE_TICKS(SETTLE_TICKS),
    .PULSE_TICKS (PULSE_TICKS)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .intervalSel(intervalSel),
    .wdEnabled  (wdEnabled),
    .wdAtLimit  (wdAtLimit),
    .settleAtEnd(settleAtEnd),
    .pulseAtEnd (pulseAtEnd)
  );

  // The supply flag bypasses the state register so reset follows it at once.
  assign resetOut  = ~running | supplyLow;
  assign resetOutN = ~resetOut;

endmodule

// File: rtl/wdsup_checker.sv
module wdsup_checker #(
  parameter int SETTLE_TICKS = 1000,
  parameter int PULSE_TICKS  = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       kick,
  input logic [1:0] intervalSel,
  input logic       supplyLow,
  input logic       resetOut,
  input logic       resetOutN
);

  localparam int MIN_HIGH = (PULSE_TICKS < SETTLE_TICKS) ? PULSE_TICKS : SETTLE_TICKS;
  localparam int CW = $clog2(SETTLE_TICKS + PULSE_TICKS + 2) + 1;

  logic armed;
  logic [CW-1:0] goodRun;
  logic [CW-1:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      goodRun <= '0;
      highRun <= '0;
    end else begin
      armed <= 1'b1;
      if (supplyLow) goodRun <= '0;
      else if (goodRun < CW'(SETTLE_TICKS)) goodRun <= goodRun + 1'b1;
      if (!resetOut) highRun <= '0;
      else if (highRun < CW'(SETTLE_TICKS + PULSE_TICKS)) highRun <= highRun + 1'b1;
    end
  end

  AST_SUPPLY_LOW_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |-> resetOut); // R4

  AST_SETTLED_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !resetOut |-> (goodRun >= CW'(SETTLE_TICKS))); // R5

  AST_MIN_RESET_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $fell(resetOut)) |-> (highRun >= CW'(MIN_HIGH))); // R3

  AST_KICK_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(kick) && !$past(resetOut) && !supplyLow) |-> !resetOut); // R6

  AST_DISABLED_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    (armed && intervalSel == 2'b11 && $past(intervalSel) == 2'b11 && !$past(resetOut)
     && !supplyLow) |-> !resetOut); // R2

  AST_POLARITY_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    resetOut != resetOutN); // R7

endmodule

bind wdt_supervisor wdsup_checker #(
  .SETTLE_TICKS(SETTLE_TICKS),
  .PULSE_TICKS (PULSE_TICKS)
) uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .kick       (kick),
  .intervalSel(intervalSel),
  .supplyLow  (supplyLow),
  .resetOut   (resetOut),
  .resetOutN  (resetOutN)
);

// File: tb/tb_wdt_supervisor.sv
module tb_wdt_supervisor;

  localparam int SHORT_LOG2 = 4;
  localparam int MED_LOG2   = 5;
  localparam int LONG_LOG2  = 6;
  localparam int SETTLE     = 12;
  localparam int PULSE      = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic kick = 1'b0;
  logic [1:0] intervalSel = 2'b00;
  logic supplyLow = 1'b0;
  logic resetOut, resetOutN;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wdt_supervisor #(
    .SHORT_LOG2  (SHORT_LOG2),
    .MED_LOG2    (MED_LOG2),
    .LONG_LOG2   (LONG_LOG2),
    .SETTLE_TICKS(SETTLE),
    .PULSE_TICKS (PULSE)
  ) dut (
    .clk        (clk),
    .rstN       (rstN),
    .kick       (kick),
    .intervalSel(intervalSel),
    .supplyLow  (supplyLow),
    .resetOut   (resetOut),
    .resetOutN  (resetOutN)
  );

  // Each row: select code, then expected period in cycles.
  localparam int NVEC = 4;
  localparam logic [17:0] VECS [NVEC] = '{
    {2'b00, 16'd16},
    {2'b01, 16'd32},
    {2'b10, 16'd64},
    {2'b00, 16'd16}
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Counts negedges with reset at the given level, starting at the current one.
  task automatic countLevel(input logic level, output int n);
    n = 0;
    while (resetOut == level && n < 5000) begin
      if (resetOutN == resetOut) begin
        checks++;
        failures++;
        $display("FAIL R7 actual=%0b expected=%0b", resetOutN, ~resetOut);
      end
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    @(negedge clk);
    check("R8 reset state", resetOut, 1);
    check("R7 reset state", resetOutN, 0);
    @(negedge clk);
    rstN = 1'b1;
    countLevel(1'b1, n);
    check("R8 settle after power-on", n, SETTLE);

    foreach (VECS[i]) begin
      intervalSel = VECS[i][17:16];
      countLevel(1'b0, n);
      check("R1 period", n, int'(VECS[i][15:0]));
      countLevel(1'b1, n);
      check("R3 pulse width", n, PULSE);
    end

    // R6: periodic kicks keep reset low well past the short period.
    intervalSel = 2'b00;
    for (int k = 0; k < 6; k++) begin
      repeat (9) @(negedge clk);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
    end
    check("R6 kicked run stays out of reset", resetOut, 0);
    countLevel(1'b0, n);
    check("R6 period after last kick", n, 16);
    // R6: kick during the pulse must not shorten it.
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    countLevel(1'b1, n);
    check("R6 pulse with kick", n + 1, PULSE);

    // R2: disabled code, then a full short period after re-enable.
    intervalSel = 2'b11;
    countLevel(1'b0, n);
    check("R2 disabled no reset", n, 5000);
    intervalSel = 2'b00;
    countLevel(1'b0, n);
    check("R2 full period after re-enable", n, 16);
    countLevel(1'b1, n);

    // R4: immediate assertion, and R5 settle with restart.
    repeat (3) @(negedge clk);
    supplyLow = 1'b1;
    #1;
    check("R4 same-cycle reset", resetOut, 1);
    check("R7 low polarity", resetOutN, 0);
    repeat (3) @(negedge clk);
    supplyLow = 1'b0;
    repeat (5) @(negedge clk);
    check("R5 still held", resetOut, 1);
    supplyLow = 1'b1;
    @(negedge clk);
    supplyLow = 1'b0;
    countLevel(1'b1, n);
    check("R5 settle restart", n, SETTLE);

    // R9: supply event during a watchdog pulse.
    countLevel(1'b0, n);
    check("R1 period before R9", n, 16);
    @(negedge clk);
    supplyLow = 1'b1;
    repeat (2) @(negedge clk);
    supplyLow = 1'b0;
    countLevel(1'b1, n);
    check("R9 settle replaces pulse", n, SETTLE);

    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule